// File: doc/BRIEF.md
# Way-Partitioned Cache Tag and Replacement Unit

This block is the tag and replacement core of a set-associative shared cache whose allocation is divided among classes of service. Every request carries the ID of the core that issued it. The core ID selects a class of service, and the class selects a bitmask of the ways that the request may fill. A lookup compares the tag against every way and ignores the mask, so a line can hit in any way. A miss chooses its victim only from the ways the mask permits. The masks of different classes may overlap.

Software changes the class masks and the core-to-class assignment at run time through a single write port. A mask write with fewer than two bits set is dropped, and the old mask stays in force. A change applies from the next request onward and leaves the resident lines valid. Line data, the memory side and coherence are outside this block.

The address is split as follows. Bits [5:0] are the byte offset within a 64-byte line. Bits [11:6] select one of 64 sets. Bits [31:12] are the tag. Each set has 16 ways and its own tree pseudo-LRU state.

Top module: `wp_cache_alloc`

## Requirements
- R1: A request whose tag matches a valid line in its set reports `rsp_hit`=1 and the matching way, whether or not that way is in the requester's mask. No line changes.
- R2: A miss fills exactly one way, and that way is set in the requester's class mask. Lines in ways outside that mask are not evicted.
- R3: On a miss, if any permitted way of the set is invalid, the lowest-numbered permitted invalid way is filled and `rsp_evict`=0.
- R4: On a miss where every permitted way is valid, the victim comes from a 15-node tree pseudo-LRU. At each node the walk follows the stored direction, unless that subtree holds no permitted way, in which case it takes the other branch. Every access updates the nodes on its path to point away from the way it used, and the response reports `rsp_evict`=1. After ways 0 to 15 of a set are used in order, four misses with the full mask evict ways 0, 8, 4 and 12. Two permitted ways in one leaf pair alternate.
- R5: A mask write (`cfg_sel`=0, `cfg_idx`=class) is applied only if `cfg_wdata` has at least two bits set. Otherwise it is ignored and the prior mask is kept.
- R6: Two classes may hold overlapping masks, and a miss from either class may evict a line that the other class filled in a shared way.
- R7: A class write (`cfg_sel`=1, `cfg_idx`=core) assigns `cfg_wdata[1:0]` as that core's class. Later misses from that core follow the new class's mask.
- R8: A mask change invalidates no line. Existing lines still hit, and the next miss uses the new mask.
- R9: After reset, every class mask is all ones, every core is in class 0, every line is invalid and `rsp_valid` is 0.
- R10: The response to a request taken at a clock edge appears at that same edge's register outputs. `rsp_valid` is 1 for exactly the cycles that follow a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_core | input | 2 | Requesting core ID |
| req_addr | input | 32 | Byte address of the request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: class mask write, 1: core class write |
| cfg_idx | input | 2 | Class index (mask write) or core index (class write) |
| cfg_wdata | input | 16 | Way mask, or class number in bits [1:0] |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit |
| rsp_way | output | 4 | Way that hit or was filled |
| rsp_evict | output | 1 | The filled way held a valid line |

## Verification
The hardest case to reach from the ports is a restricted pseudo-LRU walk. It needs a set in which every permitted way is valid and whose tree state points into ways the requester may not use, so that the walk has to take the other branch. The stimulus fills a set completely with a full-mask core, fixing a known tree state. It then sends misses from a core whose class owns a single leaf pair, and from two classes that share that pair. The expected victims follow from the order of the earlier accesses.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;
  typedef enum logic {
    CFG_MASK  = 1'b0,
    CFG_CLASS = 1'b1
  } cfg_kind_e;
endpackage

// File: rtl/wp_cfg_regs.sv
module wp_cfg_regs
  import wp_cache_pkg::*;
#(
  parameter int NUM_WAYS    = 16,
  parameter int NUM_CLASSES = 4,
  parameter int NUM_CORES   = 4,
  parameter int IDX_W       = 2,
  localparam int CLS_W      = $clog2(NUM_CLASSES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  cfg_kind_e                       cfg_kind,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic [NUM_WAYS-1:0]             cfg_wdata,
  output logic [NUM_CLASSES*NUM_WAYS-1:0] mask_flat,
  output logic [NUM_CORES*CLS_W-1:0]      core_cls_flat
);
  logic [NUM_WAYS-1:0] mask_q [NUM_CLASSES];
  logic [CLS_W-1:0]    cls_q  [NUM_CORES];
  logic                mask_ok;

  function automatic int unsigned ones(input logic [NUM_WAYS-1:0] v);
    int unsigned n = 0;
    for (int i = 0; i < NUM_WAYS; i++) n += int'(v[i]);
    return n;
  endfunction

  assign mask_ok = (ones(cfg_wdata) >= 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CLASSES; c++) mask_q[c] <= '1;
      for (int k = 0; k < NUM_CORES; k++) cls_q[k] <= '0;
    end else if (cfg_we) begin
      if (cfg_kind == CFG_MASK) begin
        for (int c = 0; c < NUM_CLASSES; c++)
          if (int'(cfg_idx) == c && mask_ok) mask_q[c] <= cfg_wdata;
      end else begin
        for (int k = 0; k < NUM_CORES; k++)
          if (int'(cfg_idx) == k) cls_q[k] <= cfg_wdata[CLS_W-1:0];
      end
    end
  end

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_mask
    assign mask_flat[c*NUM_WAYS +: NUM_WAYS] = mask_q[c];
  end
  for (genvar k = 0; k < NUM_CORES; k++) begin : g_cls
    assign core_cls_flat[k*CLS_W +: CLS_W] = cls_q[k];
  end
endmodule

// File: rtl/wp_victim_pick.sv
module wp_victim_pick #(
  parameter int NUM_WAYS = 16,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] row_valid,
  input  logic [NUM_WAYS-1:0] allow,
  input  logic [NUM_WAYS-2:0] plru,
  output logic [WAY_W-1:0]    victim,
  output logic                victim_live
);
  // node_any[n]: subtree rooted at heap node n holds a permitted way
  logic [2*NUM_WAYS-1:1] node_any;
  logic [WAY_W-1:0]      free_way, tree_way;
  logic                  free_found;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_leaf
    assign node_any[NUM_WAYS+w] = allow[w];
  end
  for (genvar n = 1; n < NUM_WAYS; n++) begin : g_node
    assign node_any[n] = node_any[2*n] | node_any[2*n+1];
  end

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = NUM_WAYS-1; w >= 0; w--) begin
      if (allow[w] && !row_valid[w]) begin
        free_found = 1'b1;
        free_way   = WAY_W'(w);
      end
    end
  end

  always_comb begin
    int  idx;
    logic go;
    idx = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      go = plru[idx-1];
      if (!node_any[2*idx+int'(go)]) go = ~go;
      idx = 2*idx + int'(go);
    end
    tree_way = WAY_W'(idx - NUM_WAYS);
  end

  assign victim      = free_found ? free_way : tree_way;
  assign victim_live = !free_found;
endmodule

// File: rtl/wp_cache_alloc.sv
module wp_cache_alloc
  import wp_cache_pkg::*;
#(
  parameter int NUM_WAYS    = 16,
  parameter int NUM_SETS    = 64,
  parameter int LINE_BYTES  = 64,
  parameter int ADDR_W      = 32,
  parameter int NUM_CLASSES = 4,
  parameter int NUM_CORES   = 4,
  localparam int WAY_W      = $clog2(NUM_WAYS),
  localparam int SET_W      = $clog2(NUM_SETS),
  localparam int OFF_W      = $clog2(LINE_BYTES),
  localparam int TAG_W      = ADDR_W - SET_W - OFF_W,
  localparam int CORE_W     = $clog2(NUM_CORES),
  localparam int CLS_W      = $clog2(NUM_CLASSES),
  localparam int IDX_W      = (NUM_CLASSES > NUM_CORES) ? $clog2(NUM_CLASSES) : $clog2(NUM_CORES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [CORE_W-1:0]   req_core,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [NUM_WAYS-1:0] cfg_wdata,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [WAY_W-1:0]    rsp_way,
  output logic                rsp_evict
);
  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-2:0] plru_q  [NUM_SETS];

  logic [NUM_CLASSES*NUM_WAYS-1:0] mask_flat;
  logic [NUM_CORES*CLS_W-1:0]      core_cls_flat;
  logic [CLS_W-1:0]    req_cls;
  logic [NUM_WAYS-1:0] req_mask;
  logic [SET_W-1:0]    set_idx;
  logic [TAG_W-1:0]    req_tag;
  logic [NUM_WAYS-1:0] hit_vec;
  logic                any_hit;
  logic [WAY_W-1:0]    hit_way, fill_way, used_way;
  logic                fill_live, miss_fill;

  function automatic logic [NUM_WAYS-2:0] plru_touch(input logic [NUM_WAYS-2:0] cur,
                                                     input logic [WAY_W-1:0]    way);
    logic [NUM_WAYS-2:0] nxt = cur;
    int idx = 1;
    for (int lvl = 0; lvl < WAY_W; lvl++) begin
      nxt[idx-1] = ~way[WAY_W-1-lvl];
      idx = 2*idx + int'(way[WAY_W-1-lvl]);
    end
    return nxt;
  endfunction

  wp_cfg_regs #(
    .NUM_WAYS(NUM_WAYS), .NUM_CLASSES(NUM_CLASSES), .NUM_CORES(NUM_CORES), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind_e'(cfg_sel)),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .mask_flat(mask_flat), .core_cls_flat(core_cls_flat)
  );

  assign set_idx  = req_addr[OFF_W +: SET_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_cls  = core_cls_flat[req_core*CLS_W +: CLS_W];
  assign req_mask = mask_flat[req_cls*NUM_WAYS +: NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[set_idx][w] && (tag_q[set_idx][w] == req_tag);
  end
  assign any_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  wp_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .row_valid(valid_q[set_idx]), .allow(req_mask), .plru(plru_q[set_idx]),
    .victim(fill_way), .victim_live(fill_live)
  );

  assign miss_fill = req_valid && !any_hit;
  assign used_way  = any_hit ? hit_way : fill_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_evict <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        plru_q[set_idx] <= plru_touch(plru_q[set_idx], used_way);
        rsp_hit   <= any_hit;
        rsp_way   <= used_way;
        rsp_evict <= !any_hit && fill_live;
        if (!any_hit) valid_q[set_idx][fill_way] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (miss_fill) tag_q[set_idx][fill_way] <= req_tag;
  end
endmodule

// File: rtl/wp_cache_alloc_chk.sv
module wp_cache_alloc_chk #(
  parameter int NUM_WAYS    = 16,
  parameter int NUM_CLASSES = 4,
  localparam int WAY_W      = $clog2(NUM_WAYS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            req_valid,
  input logic                            rsp_valid,
  input logic                            rsp_hit,
  input logic                            cfg_we,
  input logic                            cfg_sel,
  input logic [NUM_WAYS-1:0]             cfg_wdata,
  input logic [NUM_CLASSES*NUM_WAYS-1:0] mask_flat,
  input logic [NUM_WAYS-1:0]             req_mask,
  input logic [NUM_WAYS-1:0]             hit_vec,
  input logic                            miss_fill,
  input logic [WAY_W-1:0]                fill_way
);
  p_hit_unique_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot0(hit_vec));

  p_hit_reported_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (|hit_vec)) |=> rsp_hit);

  p_fill_in_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fill |-> req_mask[fill_way]);

  p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && ($countones(cfg_wdata) < 2)) |=> $stable(mask_flat));

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_floor
    p_mask_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mask_flat[c*NUM_WAYS +: NUM_WAYS]) >= 2);
  end

  p_rsp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
endmodule

bind wp_cache_alloc wp_cache_alloc_chk #(
  .NUM_WAYS(NUM_WAYS), .NUM_CLASSES(NUM_CLASSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
  .mask_flat(mask_flat), .req_mask(req_mask), .hit_vec(hit_vec),
  .miss_fill(miss_fill), .fill_way(fill_way)
);

// File: tb/test_wp_cache_alloc.sv
`timescale 1ns/1ps
module test_wp_cache_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_core = '0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_wdata = '0;
  logic        rsp_valid, rsp_hit, rsp_evict;
  logic [3:0]  rsp_way;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wp_cache_alloc i_wp_cache_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_addr(req_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .rsp_evict(rsp_evict)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // address = tag[31:12] | set[11:6] | offset[5:0]
  task automatic access(input int core, input int set, input int tag,
                        input bit ehit, input int eway, input bit eev, input string rq);
    @(negedge clk);
    req_valid = 1'b1;
    req_core  = 2'(core);
    req_addr  = {20'(tag), 6'(set), 6'h15};
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {rq, " valid"}, int'(rsp_valid), 1);
    check(rsp_hit == ehit, {rq, " hit"}, int'(rsp_hit), int'(ehit));
    check(int'(rsp_way) == eway, {rq, " way"}, int'(rsp_way), eway);
    check(rsp_evict == eev, {rq, " evict"}, int'(rsp_evict), int'(eev));
  endtask

  task automatic cfg(input bit sel, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 2'(idx); cfg_wdata = 16'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R9 reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 idle", int'(rsp_valid), 0);

    // R9: defaults give every core class 0 with a full mask
    access(3, 5, 7, 0, 0, 0, "R9 core3 default");
    access(2, 5, 8, 0, 1, 0, "R9 core2 default");

    // R3: sequential fill of set 0 from the lowest way upward
    for (int w = 0; w < 16; w++) access(0, 0, 100 + w, 0, w, 0, "R3 fill");
    // R1: each resident line hits in its own way
    for (int w = 0; w < 16; w++) access(0, 0, 100 + w, 1, w, 0, "R1 hit");
    // R4: full-mask tree victims after in-order use
    access(0, 0, 200, 0, 0, 1, "R4 victim a");
    access(0, 0, 201, 0, 8, 1, "R4 victim b");
    access(0, 0, 202, 0, 4, 1, "R4 victim c");
    access(0, 0, 203, 0, 12, 1, "R4 victim d");

    // R5: class1 gets ways 4,5; short masks are dropped
    cfg(0, 1, 16'h0030);
    cfg(0, 1, 16'h0001);
    cfg(0, 1, 16'h0000);
    // R7: core1 moves to class1
    cfg(1, 1, 1);
    access(1, 1, 300, 0, 4, 0, "R5 mask kept");
    access(1, 1, 301, 0, 5, 0, "R5 mask kept");
    access(1, 1, 302, 0, 4, 1, "R4 pair alternates");
    access(1, 1, 303, 0, 5, 1, "R4 pair alternates");

    // R1: hits outside the requester's mask
    access(1, 0, 109, 1, 9, 0, "R1 hit outside mask");
    access(1, 0, 200, 1, 0, 0, "R1 hit outside mask");
    // R2: full set, restricted victim is way 5 (pair node points away from 4)
    access(1, 0, 400, 0, 5, 1, "R2 restricted evict");
    access(0, 0, 109, 1, 9, 0, "R2 other way untouched");
    access(0, 0, 200, 1, 0, 0, "R2 other way untouched");
    access(0, 0, 202, 1, 4, 0, "R2 other way untouched");

    // R6: class2 overlaps class1 on ways 4,5
    cfg(0, 2, 16'h0030);
    cfg(1, 2, 2);
    access(2, 2, 500, 0, 4, 0, "R6 overlap fill");
    access(2, 2, 501, 0, 5, 0, "R6 overlap fill");
    access(1, 2, 502, 0, 4, 1, "R6 cross-class evict");
    access(2, 2, 501, 1, 5, 0, "R6 shared line hit");

    // R3: sparse mask fills its lowest free permitted way first
    cfg(0, 3, 16'hA0A0);
    cfg(1, 3, 3);
    access(3, 3, 600, 0, 5, 0, "R3 sparse");
    access(3, 3, 601, 0, 7, 0, "R3 sparse");
    access(3, 3, 602, 0, 13, 0, "R3 sparse");
    access(3, 3, 603, 0, 15, 0, "R3 sparse");
    access(0, 3, 604, 0, 0, 0, "R3 gap below");

    // R8: narrowing class0 keeps lines, next miss obeys the new mask
    cfg(0, 0, 16'h000C);
    access(0, 0, 109, 1, 9, 0, "R8 line kept");
    access(0, 6, 700, 0, 2, 0, "R8 new mask");
    access(0, 6, 701, 0, 3, 0, "R8 new mask");

    // R7: core1 back to class0 follows the new mask
    cfg(1, 1, 0);
    access(1, 7, 800, 0, 2, 0, "R7 remap");

    @(negedge clk);
    check(rsp_valid == 1'b0, "R10 idle after", int'(rsp_valid), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule